// File: doc/BRIEF.md
# SPI Serial Memory Command Front-End

This block is the slave-side command interpreter for a byte-wide serial memory. It watches the chip-select, serial clock, hold and serial-in pins. All four pass through two-flop synchronisers, and the block detects their edges in the system clock domain. It builds each instruction byte and decides what the instruction asks for. It then either issues a one-cycle pulse to downstream logic or moves into an address, data-in or data-out phase.

Reads fetch bytes through a synchronous read port with one cycle of latency, one byte ahead of need, and stream them out most significant bit first. Writes and status writes are passed on as byte pulses that carry an address and data. The policy behind a write is left to the blocks behind this one: enable latch, protection and the page buffer.

Chip-select high, hold, or a rejected instruction keeps the serial output undriven. The output enable `so_en_o` models the tri-state. The serial clock half period must be at least four system clocks.

Top module: `spi_mem_front`

## Requirements
- R1: After reset `so_en_o` is 0 and no pulse output is high. A falling edge of chip select starts a new instruction whatever state came before. Bits are taken on SCK rising edges, most significant bit first.
- R2: The instruction is decoded with bit 3 ignored and bits 7:4 required to be zero. Low bits 110 pulse `wren_o` and 100 pulse `wrdi_o`, once per instruction.
- R3: Any other instruction byte locks the interface until the next chip-select fall. While locked, SI is ignored, no pulse is issued, and `so_en_o` stays 0.
- R4: A read (low bits 011) takes a 16-bit address, of which only the low AW bits are used. From the SCK falling edge after the last address bit, the block drives the stored byte MSB first, one bit per falling edge, and SI is ignored.
- R5: While chip select stays low, a read keeps going, one address up per byte. After address 2^AW-1 it continues at address 0.
- R6: Read status (low bits 101) drives `status_i` out MSB first, repeated for every further byte.
- R7: While `busy_i` is high, every instruction other than read status is treated as rejected (as in R3).
- R8: Write status (low bits 001) pulses `stat_wr_o` once with the first data byte on `stat_data_o`. Later bytes are ignored.
- R9: A write (low bits 010) takes a 16-bit address. Each complete data byte then pulses `wr_byte_o` with `wr_data_o` and with `wr_addr_o` starting at the address and rising by one per byte. Chip select rising pulses `wr_done_o` only if at least one byte was complete.
- R10: HOLD low while SCK is low pauses the transfer, and HOLD high while SCK is low resumes it. While paused, `so_en_o` is 0 and SCK edges and SI are ignored, so the transfer carries on unchanged after release.
- R11: While chip select is high, `so_en_o` is 0 and SCK and SI activity has no effect.
- R12: SCK idling low (mode 0) and idling high (mode 3) give the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock pin |
| cs_ni | input | 1 | Chip select, active low |
| hold_ni | input | 1 | Hold pause, active low |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_en_o | output | 1 | Output driver enable (0 = high impedance) |
| busy_i | input | 1 | Internal write cycle in progress |
| status_i | input | 8 | Status byte returned by read status |
| mem_addr_o | output | AW | Array read address |
| mem_data_i | input | 8 | Array read data, one cycle after address |
| wren_o | output | 1 | Write-enable instruction pulse |
| wrdi_o | output | 1 | Write-disable instruction pulse |
| stat_wr_o | output | 1 | Status write pulse |
| stat_data_o | output | 8 | Status write value |
| wr_byte_o | output | 1 | Write data byte pulse |
| wr_addr_o | output | AW | Address for the write byte |
| wr_data_o | output | 8 | Write data byte |
| wr_done_o | output | 1 | Write transaction closed by chip select |

## Verification
The bench targets these corner cases:
- **Read wrap at the top of the array.** A front-end without the wrap would stall, or run past the top and return wrong bytes.
- **Address bits above the array width.** If these were decoded, a read at a high address would return data from the wrong location.
- **Locked state after a bad instruction.** A later byte that matches a valid instruction must stay inert; a broken lockout would act on it.
- **Pause in the middle of a byte.** Junk SCK pulses during hold would be shifted in, corrupting write data and knocking read data out of step.
- **Busy gating.** A missing gate would let enables through during a busy cycle.
- **Write closed after zero data bytes.** A loose commit rule would report a done with nothing written.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_OPC, PH_ADDR, PH_RDAT, PH_WDAT, PH_SRD, PH_SWR, PH_LOCK
  } phase_e;

  typedef enum logic [2:0] {
    C_BAD, C_WREN, C_WRDI, C_RDSR, C_WRSR, C_READ, C_WRITE
  } cmd_e;

  // bit 3 is don't-care, upper nibble must be zero
  function automatic cmd_e decode_op(input logic [7:0] b);
    cmd_e c;
    c = C_BAD;
    if (b[7:4] == 4'h0) begin
      case (b[2:0])
        3'b110:  c = C_WREN;
        3'b100:  c = C_WRDI;
        3'b101:  c = C_RDSR;
        3'b001:  c = C_WRSR;
        3'b011:  c = C_READ;
        3'b010:  c = C_WRITE;
        default: c = C_BAD;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int          W   = 4,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST;
      s2_q <= RST;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/spi_mem_pins.sv
module spi_mem_pins (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic hold_ni,
  input  logic si_i,
  output logic sel_o,
  output logic held_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic rise_o,
  output logic fall_o,
  output logic si_o
);
  localparam int NPIN = 4;
  // order {sck, cs_n, hold_n, si}
  localparam logic [NPIN-1:0] PIN_RST = 4'b0110;

  logic [NPIN-1:0] pin_s;
  logic sck_s, csn_s, holdn_s;
  logic sck_q, csn_q, held_q;

  spi_mem_sync #(.W(NPIN), .RST(PIN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, cs_ni, hold_ni, si_i}),
    .q_o   (pin_s)
  );

  assign {sck_s, csn_s, holdn_s, si_o} = pin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      csn_q  <= 1'b1;
      held_q <= 1'b0;
    end else begin
      sck_q <= sck_s;
      csn_q <= csn_s;
      if (csn_s)       held_q <= 1'b0;
      else if (!sck_s) held_q <= !holdn_s;  // hold changes only with SCK low
    end
  end

  assign sel_o     = !csn_s;
  assign held_o    = held_q;
  assign cs_fall_o = csn_q && !csn_s;
  assign cs_rise_o = !csn_q && csn_s;
  assign rise_o    = sel_o && !held_q && sck_s && !sck_q;
  assign fall_o    = sel_o && !held_q && !sck_s && sck_q;

  a_r10_hold_needs_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q |-> $past(!csn_s));
  a_r11_no_edge_desel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s |-> !(rise_o || fall_o));
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          held_i,
  input  logic          cs_fall_i,
  input  logic          cs_rise_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          si_i,
  input  logic          busy_i,
  input  logic [7:0]    status_i,
  input  logic [7:0]    mem_data_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          so_o,
  output logic          so_en_o,
  output logic          wren_o,
  output logic          wrdi_o,
  output logic          stat_wr_o,
  output logic [7:0]    stat_data_o,
  output logic          wr_byte_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          wr_done_o
);
  localparam int ADDR_BITS = 16;
  localparam logic [3:0] BYTE_LAST = 4'd7;
  localparam logic [3:0] ADDR_LAST = 4'(ADDR_BITS - 1);

  phase_e        phase_q;
  logic [3:0]    bcnt_q;
  logic [6:0]    in_sh_q;
  logic [AW-2:0] adr_sh_q;
  logic          rd_q, ovld_q, wany_q;
  logic [AW-1:0] wadr_q, radr_q;
  logic [7:0]    out_sh_q;
  logic [2:0]    ocnt_q;

  logic [7:0]    in_byte;
  logic [AW-1:0] adr_full;
  cmd_e          cmd;
  logic          out_ph;

  assign in_byte  = {in_sh_q, si_i};
  assign adr_full = {adr_sh_q, si_i};
  assign cmd      = decode_op(in_byte);
  assign out_ph   = (phase_q == PH_RDAT) || (phase_q == PH_SRD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      bcnt_q      <= '0;
      in_sh_q     <= '0;
      adr_sh_q    <= '0;
      rd_q        <= 1'b0;
      ovld_q      <= 1'b0;
      wany_q      <= 1'b0;
      wadr_q      <= '0;
      radr_q      <= '0;
      out_sh_q    <= '0;
      ocnt_q      <= '0;
      wren_o      <= 1'b0;
      wrdi_o      <= 1'b0;
      stat_wr_o   <= 1'b0;
      stat_data_o <= '0;
      wr_byte_o   <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_done_o   <= 1'b0;
    end else begin
      wren_o    <= 1'b0;
      wrdi_o    <= 1'b0;
      stat_wr_o <= 1'b0;
      wr_byte_o <= 1'b0;
      wr_done_o <= 1'b0;
      if (cs_fall_i) begin
        phase_q <= PH_OPC;
        bcnt_q  <= '0;
        ocnt_q  <= '0;
        ovld_q  <= 1'b0;
        wany_q  <= 1'b0;
      end else if (cs_rise_i) begin
        if (phase_q == PH_WDAT && wany_q) wr_done_o <= 1'b1;
        phase_q <= PH_IDLE;
        ovld_q  <= 1'b0;
      end else begin
        if (rise_i) begin
          in_sh_q <= in_byte[6:0];
          bcnt_q  <= bcnt_q + 4'd1;
          case (phase_q)
            PH_OPC: if (bcnt_q == BYTE_LAST) begin
              bcnt_q <= '0;
              if (cmd == C_BAD || (busy_i && cmd != C_RDSR)) phase_q <= PH_LOCK;
              else begin
                case (cmd)
                  C_WREN:  begin wren_o <= 1'b1; phase_q <= PH_IDLE; end
                  C_WRDI:  begin wrdi_o <= 1'b1; phase_q <= PH_IDLE; end
                  C_RDSR:  phase_q <= PH_SRD;
                  C_WRSR:  phase_q <= PH_SWR;
                  C_READ:  begin rd_q <= 1'b1; phase_q <= PH_ADDR; end
                  C_WRITE: begin rd_q <= 1'b0; phase_q <= PH_ADDR; end
                  default: phase_q <= PH_LOCK;
                endcase
              end
            end
            PH_ADDR: begin
              adr_sh_q <= {adr_sh_q[AW-3:0], si_i};  // high bits fall off
              if (bcnt_q == ADDR_LAST) begin
                bcnt_q <= '0;
                if (rd_q) begin
                  radr_q  <= adr_full;
                  phase_q <= PH_RDAT;
                end else begin
                  wadr_q  <= adr_full;
                  phase_q <= PH_WDAT;
                end
              end
            end
            PH_WDAT: if (bcnt_q == BYTE_LAST) begin
              bcnt_q    <= '0;
              wr_byte_o <= 1'b1;
              wr_data_o <= in_byte;
              wr_addr_o <= wadr_q;
              wadr_q    <= wadr_q + 1'b1;
              wany_q    <= 1'b1;
            end
            PH_SWR: if (bcnt_q == BYTE_LAST) begin
              stat_wr_o   <= 1'b1;
              stat_data_o <= in_byte;
              phase_q     <= PH_IDLE;
            end
            default: ;
          endcase
        end
        if (fall_i && out_ph) begin
          ocnt_q <= ocnt_q + 3'd1;
          if (ocnt_q == 3'd0) begin
            ovld_q <= 1'b1;
            if (phase_q == PH_RDAT) begin
              out_sh_q <= mem_data_i;
              radr_q   <= radr_q + 1'b1;  // prefetch next byte
            end else begin
              out_sh_q <= status_i;
            end
          end else begin
            out_sh_q <= {out_sh_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign mem_addr_o = radr_q;
  assign so_o       = out_sh_q[7];
  assign so_en_o    = sel_i && !held_i && ovld_q && out_ph;

  a_r9_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wren_o, wrdi_o, stat_wr_o, wr_byte_o, wr_done_o}));
  a_r7_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wren_o || wrdi_o) |-> $past(!busy_i));
  a_r3_lock_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_LOCK) |-> (!so_en_o && !wr_byte_o && !stat_wr_o));
  a_r5_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RDAT && !fall_i && !cs_fall_i) |=> $stable(radr_q));
  a_r9_done_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |-> $past(wany_q));
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front #(
  parameter int AW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          cs_ni,
  input  logic          hold_ni,
  input  logic          si_i,
  output logic          so_o,
  output logic          so_en_o,
  input  logic          busy_i,
  input  logic [7:0]    status_i,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_data_i,
  output logic          wren_o,
  output logic          wrdi_o,
  output logic          stat_wr_o,
  output logic [7:0]    stat_data_o,
  output logic          wr_byte_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          wr_done_o
);
  logic sel, held, cs_fall, cs_rise, rise, fall, si_s;

  spi_mem_pins u_pins (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sck_i    (sck_i),
    .cs_ni    (cs_ni),
    .hold_ni  (hold_ni),
    .si_i     (si_i),
    .sel_o    (sel),
    .held_o   (held),
    .cs_fall_o(cs_fall),
    .cs_rise_o(cs_rise),
    .rise_o   (rise),
    .fall_o   (fall),
    .si_o     (si_s)
  );

  spi_mem_ctrl #(.AW(AW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .held_i     (held),
    .cs_fall_i  (cs_fall),
    .cs_rise_i  (cs_rise),
    .rise_i     (rise),
    .fall_i     (fall),
    .si_i       (si_s),
    .busy_i     (busy_i),
    .status_i   (status_i),
    .mem_data_i (mem_data_i),
    .mem_addr_o (mem_addr_o),
    .so_o       (so_o),
    .so_en_o    (so_en_o),
    .wren_o     (wren_o),
    .wrdi_o     (wrdi_o),
    .stat_wr_o  (stat_wr_o),
    .stat_data_o(stat_data_o),
    .wr_byte_o  (wr_byte_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .wr_done_o  (wr_done_o)
  );

  a_r10_hold_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held |-> !so_en_o);
  a_r11_desel_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |-> !so_en_o);
endmodule

// File: tb/spi_mem_front_tb_top.sv
module spi_mem_front_tb_top;
  localparam int AW = 15;
  localparam int HP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
  logic busy = 1'b0;
  logic [7:0] stat = 8'h00;
  logic so_o, so_en_o;
  logic [AW-1:0] mem_a;
  logic [7:0] mem_d;
  logic wren_o, wrdi_o, stat_wr_o, wr_byte_o, wr_done_o;
  logic [7:0] stat_data_o, wr_data_o;
  logic [AW-1:0] wr_addr_o;

  int n_chk = 0, n_bad = 0;
  int n_wren = 0, n_wrdi = 0, n_swr = 0, n_wb = 0, n_done = 0, n_en = 0;
  logic [AW-1:0] wa [16];
  logic [7:0]    wd [16];

  always #4 clk = !clk;

  spi_mem_front #(.AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .hold_ni(hold_n),
    .si_i(si), .so_o(so_o), .so_en_o(so_en_o), .busy_i(busy), .status_i(stat),
    .mem_addr_o(mem_a), .mem_data_i(mem_d), .wren_o(wren_o), .wrdi_o(wrdi_o),
    .stat_wr_o(stat_wr_o), .stat_data_o(stat_data_o), .wr_byte_o(wr_byte_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_done_o(wr_done_o)
  );

  function automatic logic [7:0] fmem(input logic [AW-1:0] a);
    logic [7:0] hi;
    hi = 8'({1'b0, a[14:8]}) * 8'd37;
    return a[7:0] ^ hi ^ 8'h5A;
  endfunction

  always @(posedge clk) mem_d <= fmem(mem_a);

  always @(posedge clk) begin
    if (wren_o)    n_wren <= n_wren + 1;
    if (wrdi_o)    n_wrdi <= n_wrdi + 1;
    if (stat_wr_o) n_swr  <= n_swr + 1;
    if (wr_done_o) n_done <= n_done + 1;
    if (so_en_o)   n_en   <= n_en + 1;
    if (wr_byte_o) begin
      wa[n_wb[3:0]] <= wr_addr_o;
      wd[n_wb[3:0]] <= wr_data_o;
      n_wb <= n_wb + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic en);
    en = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = tx[i];
      tick(HP);
      rx[i] = so_o; en = en & so_en_o;
      sck = 1'b1;
      tick(HP);
    end
  endtask

  task automatic sbyte(input logic [7:0] tx);
    logic [7:0] r; logic e;
    xbyte(tx, r, e);
  endtask

  task automatic cs_begin(input bit m3);
    sck = m3; tick(HP); cs_n = 1'b0; tick(HP);
  endtask

  task automatic cs_end(input bit m3);
    sck = m3; tick(HP); cs_n = 1'b1; tick(2 * HP);
  endtask

  task automatic do_read(input bit m3, input logic [15:0] a, input int n, input string req);
    logic [7:0] rx, ex; logic en; logic [AW-1:0] ai;
    cs_begin(m3);
    sbyte($urandom_range(0, 1) ? 8'h0B : 8'h03);
    sbyte(a[15:8]); sbyte(a[7:0]);
    for (int i = 0; i < n; i++) begin
      xbyte(8'($urandom), rx, en);
      ai = a[AW-1:0] + AW'(i);
      ex = fmem(ai);
      chk(rx == ex && en, req, {23'd0, en, rx}, {24'd1, ex});
    end
    cs_end(m3);
  endtask

  task automatic do_write(input bit m3, input logic [15:0] a, input int n, input string req);
    logic [7:0] dv [4]; int b0, d0; logic [AW-1:0] ai;
    b0 = n_wb; d0 = n_done;
    cs_begin(m3);
    sbyte(8'h02); sbyte(a[15:8]); sbyte(a[7:0]);
    for (int i = 0; i < n; i++) begin dv[i] = 8'($urandom); sbyte(dv[i]); end
    cs_end(m3);
    chk(n_wb - b0 == n, req, n_wb - b0, n);
    chk(n_done - d0 == (n > 0 ? 1 : 0), req, n_done - d0, n > 0 ? 1 : 0);
    for (int i = 0; i < n; i++) begin
      ai = a[AW-1:0] + AW'(i);
      chk(wa[(b0 + i) % 16] == ai && wd[(b0 + i) % 16] == dv[i], req,
          {1'b0, wa[(b0 + i) % 16], wd[(b0 + i) % 16]}, {1'b0, ai, dv[i]});
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int w0, e0, s0;
    logic [7:0] rx, sd; logic en;
    void'($urandom(32'h1234_5678));
    tick(5); rst_n = 1'b1; tick(5);
    // R1 reset state
    chk(!so_en_o && n_wren == 0 && n_wb == 0, "R1 reset", so_en_o, 0);

    // R2 enable / disable, bit 3 both ways, both modes (R12)
    w0 = n_wren;
    cs_begin(0); sbyte(8'h06); cs_end(0);
    cs_begin(1); sbyte(8'h0E); cs_end(1);
    chk(n_wren - w0 == 2, "R2 wren R12", n_wren - w0, 2);
    w0 = n_wrdi;
    cs_begin(0); sbyte(8'h0C); cs_end(0);
    chk(n_wrdi - w0 == 1, "R2 wrdi", n_wrdi - w0, 1);

    // R3 bad opcodes, later valid-looking byte must be ignored
    w0 = n_wren; e0 = n_en;
    cs_begin(0); sbyte(8'h86); sbyte(8'h06); sbyte(8'h03); cs_end(0);
    cs_begin(1); sbyte(8'h07); sbyte(8'h06); cs_end(1);
    chk(n_wren == w0 && n_en == e0, "R3 lockout", n_wren - w0, 0);
    // R1 new CS fall restarts after lockout
    cs_begin(0); sbyte(8'h0E); cs_end(0);
    chk(n_wren - w0 == 1, "R1 restart", n_wren - w0, 1);

    // R4 reads, R12 both modes, high address bits ignored
    do_read(0, 16'h1234, 3, "R4 read m0");
    do_read(1, 16'h0ABC, 3, "R4 R12 read m3");
    do_read(0, 16'hC321, 2, "R4 high addr bits");
    // R5 wrap
    do_read(0, 16'h7FFD, 5, "R5 wrap");
    do_read(1, 16'hFFFF, 2, "R5 wrap high");

    // R6 status read repeats
    stat = 8'hA3;
    cs_begin(0); sbyte(8'h05);
    for (int i = 0; i < 3; i++) begin
      xbyte(8'hFF, rx, en);
      chk(rx == 8'hA3 && en, "R6 status", {23'd0, en, rx}, 9'h1A3);
    end
    cs_end(0);

    // R7 busy
    busy = 1'b1; w0 = n_wren; e0 = n_en; s0 = n_wb;
    cs_begin(0); sbyte(8'h06); cs_end(0);
    cs_begin(0); sbyte(8'h03); sbyte(8'h00); sbyte(8'h10); sbyte(8'h00); cs_end(0);
    cs_begin(1); sbyte(8'h02); sbyte(8'h00); sbyte(8'h10); sbyte(8'h55); cs_end(1);
    chk(n_wren == w0 && n_en == e0 && n_wb == s0, "R7 busy ignore", n_en - e0, 0);
    stat = 8'h01;
    cs_begin(1); sbyte(8'h05); xbyte(8'h00, rx, en); cs_end(1);
    chk(rx == 8'h01 && en, "R7 status while busy", rx, 1);
    busy = 1'b0;

    // R8 status write
    s0 = n_swr; sd = 8'($urandom);
    cs_begin(0); sbyte(8'h09); sbyte(sd); sbyte(~sd); cs_end(0);
    chk(n_swr - s0 == 1 && stat_data_o == sd, "R8 stat write", {n_swr - s0, stat_data_o}, {1, sd});

    // R9 writes, including zero-byte and partial trailing bits
    do_write(0, 16'h0100, 3, "R9 write");
    do_write(1, 16'hFFFE, 4, "R9 write wrap");
    do_write(0, 16'h2222, 0, "R9 empty write");
    s0 = n_wb; w0 = n_done;
    cs_begin(0); sbyte(8'h02); sbyte(8'h00); sbyte(8'h40);
    for (int i = 0; i < 5; i++) begin sck = 1'b0; si = 1'b1; tick(HP); sck = 1'b1; tick(HP); end
    cs_end(0);
    chk(n_wb == s0 && n_done == w0, "R9 partial byte", n_wb - s0, 0);

    // R10 hold during read: SO off, stream continues
    cs_begin(0); sbyte(8'h03); sbyte(8'h05); sbyte(8'h50);
    for (int i = 7; i >= 4; i--) begin
      sck = 1'b0; si = 1'b0; tick(HP); rx[i] = so_o; sck = 1'b1; tick(HP);
    end
    sck = 1'b0; tick(HP); hold_n = 1'b0; tick(HP);
    e0 = n_en;
    for (int k = 0; k < 3; k++) begin sck = 1'b1; si = 1'b1; tick(HP); sck = 1'b0; tick(HP); end
    chk(n_en == e0, "R10 hold hiz", n_en - e0, 0);
    hold_n = 1'b1; tick(HP);
    for (int i = 3; i >= 0; i--) begin
      sck = 1'b0; tick(HP); rx[i] = so_o; sck = 1'b1; tick(HP);
    end
    chk(rx == fmem(15'h0550), "R10 hold read", rx, fmem(15'h0550));
    xbyte(8'h00, rx, en);
    chk(rx == fmem(15'h0551), "R10 hold read next", rx, fmem(15'h0551));
    cs_end(0);

    // R10 hold during write: junk SI ignored
    s0 = n_wb;
    cs_begin(0); sbyte(8'h02); sbyte(8'h03); sbyte(8'h00);
    for (int i = 7; i >= 4; i--) begin sck = 1'b0; si = i[0]; tick(HP); sck = 1'b1; tick(HP); end
    sck = 1'b0; tick(HP); hold_n = 1'b0; tick(HP);
    for (int k = 0; k < 4; k++) begin si = k[0]; sck = 1'b1; tick(HP); sck = 1'b0; tick(HP); end
    hold_n = 1'b1; tick(HP);
    for (int i = 3; i >= 0; i--) begin sck = 1'b0; si = i[0]; tick(HP); sck = 1'b1; tick(HP); end
    cs_end(0);
    chk(n_wb - s0 == 1 && wd[s0 % 16] == 8'hAA, "R10 hold write", wd[s0 % 16], 8'hAA);

    // R11 activity while deselected
    w0 = n_wren; e0 = n_en;
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = (i == 2 || i == 1); tick(HP); sck = 1'b1; tick(HP);
    end
    sck = 1'b0; tick(HP);
    chk(n_wren == w0 && n_en == e0 && !so_en_o, "R11 deselected", n_wren - w0, 0);

    // random mix
    for (int t = 0; t < 30; t++) begin
      if ($urandom_range(0, 1))
        do_read(1'($urandom), 16'($urandom), $urandom_range(1, 4), "R4 R5 R12 random read");
      else
        do_write(1'($urandom), 16'($urandom), $urandom_range(1, 4), "R9 R12 random write");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule